// File: doc/BRIEF.md
# Charge-Balance Successive-Approximation Matcher

This block trims one current DAC of a stimulation channel (or of a group of channels) until its current cancels the opposing source. The opposing source keeps a fixed code that this block never drives. The difference between the two currents flows into a shared analog integrator. The integrator is outside the block; the block only controls it and reads its comparator.

A run tests the code bits one at a time, from the most significant bit down. Each trial has two steps:

- **Polarity step.** Both integrator references are set equal, the integrator runs for a fixed number of cycles, and the comparator level gives the sign of the error.
- **Timed step.** The references are set unequal, ordered by that sign, and the block counts cycles until the comparator trips. A long trip time means a small error.

The sign decides whether the trial bit stays set. Every trial's time is recorded, and the code with the longest time wins.

Three 8-bit masks select which channels take part: sourcing gates, sinking gates, and routing to the integrator. They are captured at start and applied for the whole run.

Top module: `chgbal_matcher`

## Requirements
- R1: After reset and while idle: `busy`, `done`, `intRun` and all three gate outputs are 0, and `intReset` is 1.
- R2: A `start` pulse while idle captures the three mask inputs. They drive `srcGate`, `snkGate` and `routeEn` until the run ends. Mask changes and `start` pulses during a run have no effect on the gates or on the result.
- R3: Bits are tried from bit CODE_W-1 down to bit 0. Each trial drives `trimCode` as the approximation so far with the trial bit set, so the first trial code is 0x8000 for CODE_W=16.
- R4: The polarity step holds `refEqual`=1 with `intRun`=1 for POL_CYC cycles. `cmpIn` is sampled in the last of these cycles. `cmpIn`=1 means the sourcing current is larger; 0 means the sinking current is larger.
- R5: The timed step holds `refEqual`=0 and drives `refHighFirst` with the sampled polarity. The recorded time is the number of `intRun` cycles that pass before `cmpIn` equals the polarity at a clock edge (0 if it already equals it at the first edge).
- R6: If no trip occurs within TIMEOUT_CYC cycles, the trial ends and its time is TIMEOUT_CYC. No recorded time exceeds TIMEOUT_CYC.
- R7: After a trial, the trial bit stays 1 in the approximation if the polarity was 1, and is cleared if it was 0.
- R8: The final code is the trial code with the strictly longest time. On equal times, the earlier trial is kept.
- R9: At the end of a run, `done` is high for exactly one cycle with `finalCode` and `finalTime` valid. The block then returns to idle.
- R10: `trimCode` and `refEqual` do not change while the integrator keeps running from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a matching run (accepted only while idle) |
| srcMaskIn | input | CHAN_N | Channels whose sourcing side is gated on |
| snkMaskIn | input | CHAN_N | Channels whose sinking side is gated on |
| routeMaskIn | input | CHAN_N | Channels routed to the integrator |
| cmpIn | input | 1 | Integrator comparator level |
| srcGate | output | CHAN_N | Applied sourcing gates |
| snkGate | output | CHAN_N | Applied sinking gates |
| routeEn | output | CHAN_N | Applied integrator routing |
| trimCode | output | CODE_W | Code of the DAC being adjusted |
| intReset | output | 1 | Hold the integrator in reset |
| intRun | output | 1 | Let the integrator integrate |
| refEqual | output | 1 | 1: references equal; 0: references unequal |
| refHighFirst | output | 1 | Reference order for the timed step (the polarity) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run strobe |
| finalCode | output | CODE_W | Chosen code |
| finalTime | output | TIME_W | Trip time of the chosen code |

## Verification
Some properties are checked by assertions on every cycle:

- `done` lasts exactly one cycle and only follows a busy cycle.
- Gates stay closed while idle.
- Recorded times never exceed the timeout.
- The trial code and the reference mode hold steady while the integrator runs.

The bench scenarios cover the rest, using an integrator model whose trip delay is inversely proportional to the error:

- the MSB-first trial order and the keep/clear decision on each bit;
- the reference order in the timed step;
- the timeout value and the earliest-wins tie rule;
- a run whose best match never reaches zero error;
- mask capture that ignores changes made mid-run.

// File: rtl/chgbal_pkg.sv
package chgbal_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_POL,
    ST_ARM,
    ST_TIME,
    ST_DONE
  } matchState_t;

  typedef struct packed {
    logic capture;   // latch masks, clear approximation and best
    logic setTrial;  // form next trial code
    logic timerClr;
    logic timerInc;
    logic latchPol;  // sample comparator as polarity
    logic commit;    // record time, decide bit, step bit index
    logic finish;    // release gates
  } dpStrobe_t;

endpackage

// File: rtl/chgbal_ctrl.sv
module chgbal_ctrl
  import chgbal_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       timerAtPol,
  input  logic       timerAtMax,
  input  logic       tripped,
  input  logic       lastBit,
  output dpStrobe_t  strb,
  output logic       busy,
  output logic       done,
  output logic       intRun,
  output logic       intReset,
  output logic       refEqual
);

  matchState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    busy      = 1'b1;
    done      = 1'b0;
    intRun    = 1'b0;
    intReset  = 1'b0;
    refEqual  = 1'b1;
    case (state)
      ST_IDLE: begin
        busy     = 1'b0;
        intReset = 1'b1;
        if (start) begin
          strb.capture = 1'b1;
          nextState    = ST_LOAD;
        end
      end
      ST_LOAD: begin
        intReset      = 1'b1;
        strb.setTrial = 1'b1;
        strb.timerClr = 1'b1;
        nextState     = ST_POL;
      end
      ST_POL: begin
        intRun        = 1'b1;
        strb.timerInc = 1'b1;
        if (timerAtPol) begin
          strb.latchPol = 1'b1;
          nextState     = ST_ARM;
        end
      end
      ST_ARM: begin
        intReset      = 1'b1;
        refEqual      = 1'b0;
        strb.timerClr = 1'b1;
        nextState     = ST_TIME;
      end
      ST_TIME: begin
        intRun   = 1'b1;
        refEqual = 1'b0;
        if (tripped || timerAtMax) begin
          strb.commit = 1'b1;
          nextState   = lastBit ? ST_DONE : ST_LOAD;
        end else begin
          strb.timerInc = 1'b1;
        end
      end
      ST_DONE: begin
        done        = 1'b1;
        strb.finish = 1'b1;
        nextState   = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  // R9: done is a single-cycle strobe
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: done only ends a run that was in progress
  p_done_after_run_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(busy));

endmodule

// File: rtl/chgbal_dp.sv
module chgbal_dp
  import chgbal_pkg::*;
#(
  parameter int CODE_W      = 16,
  parameter int CHAN_N      = 8,
  parameter int POL_CYC     = 16,
  parameter int TIMEOUT_CYC = 15_000_000,
  localparam int BIT_W      = $clog2(CODE_W),
  localparam int TIME_W     = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [CHAN_N-1:0] srcMaskIn,
  input  logic [CHAN_N-1:0] snkMaskIn,
  input  logic [CHAN_N-1:0] routeMaskIn,
  input  logic              cmpIn,
  output logic [CHAN_N-1:0] srcGate,
  output logic [CHAN_N-1:0] snkGate,
  output logic [CHAN_N-1:0] routeEn,
  output logic [CODE_W-1:0] trimCode,
  output logic              polarity,
  output logic [CODE_W-1:0] finalCode,
  output logic [TIME_W-1:0] finalTime,
  output logic              timerAtPol,
  output logic              timerAtMax,
  output logic              tripped,
  output logic              lastBit
);

  localparam logic [TIME_W-1:0] TIME_MAX  = TIME_W'(TIMEOUT_CYC);
  localparam logic [TIME_W-1:0] TIME_LAST = TIME_W'(TIMEOUT_CYC - 1);
  localparam logic [TIME_W-1:0] POL_LAST  = TIME_W'(POL_CYC - 1);
  localparam logic [BIT_W-1:0]  TOP_BIT   = BIT_W'(CODE_W - 1);
  localparam logic [CODE_W-1:0] ONE_CODE  = CODE_W'(1);

  logic [CODE_W-1:0] approx;
  logic [BIT_W-1:0]  bitIdx;
  logic [TIME_W-1:0] timer;
  logic              haveBest;
  logic [TIME_W-1:0] measured;

  assign timerAtPol = (timer == POL_LAST);
  assign timerAtMax = (timer == TIME_LAST);
  assign tripped    = (cmpIn == polarity);
  assign lastBit    = (bitIdx == '0);
  assign measured   = tripped ? timer : TIME_MAX;

  // channel selection held for the run
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcGate <= '0;
      snkGate <= '0;
      routeEn <= '0;
    end else if (strb.capture) begin
      srcGate <= srcMaskIn;
      snkGate <= snkMaskIn;
      routeEn <= routeMaskIn;
    end else if (strb.finish) begin
      srcGate <= '0;
      snkGate <= '0;
      routeEn <= '0;
    end
  end

  // shared cycle counter for the polarity window and the trip time
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              timer <= '0;
    else if (strb.timerClr) timer <= '0;
    else if (strb.timerInc) timer <= timer + 1'b1;
  end

  // successive approximation and best-trial tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      approx    <= '0;
      bitIdx    <= '0;
      trimCode  <= '0;
      polarity  <= 1'b0;
      haveBest  <= 1'b0;
      finalCode <= '0;
      finalTime <= '0;
    end else begin
      if (strb.capture) begin
        approx    <= '0;
        bitIdx    <= TOP_BIT;
        haveBest  <= 1'b0;
        finalCode <= '0;
        finalTime <= '0;
      end
      if (strb.setTrial) trimCode <= approx | (ONE_CODE << bitIdx);
      if (strb.latchPol) polarity <= cmpIn;
      if (strb.commit) begin
        if (!haveBest || measured > finalTime) begin
          finalCode <= trimCode;
          finalTime <= measured;
        end
        haveBest <= 1'b1;
        if (polarity) approx <= trimCode;
        bitIdx <= bitIdx - 1'b1;
      end
    end
  end

  // R6: no recorded time exceeds the timeout
  p_time_cap_r6: assert property (@(posedge clk) disable iff (!rstN)
    finalTime <= TIME_MAX);

  // R7: approximation only changes when a trial is committed or a run begins
  p_approx_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.commit) && !$past(strb.capture) |-> $stable(approx));

endmodule

// File: rtl/chgbal_matcher.sv
module chgbal_matcher
  import chgbal_pkg::*;
#(
  parameter int CODE_W      = 16,
  parameter int CHAN_N      = 8,
  parameter int POL_CYC     = 16,
  parameter int TIMEOUT_CYC = 15_000_000,
  localparam int TIME_W     = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [CHAN_N-1:0] srcMaskIn,
  input  logic [CHAN_N-1:0] snkMaskIn,
  input  logic [CHAN_N-1:0] routeMaskIn,
  input  logic              cmpIn,
  output logic [CHAN_N-1:0] srcGate,
  output logic [CHAN_N-1:0] snkGate,
  output logic [CHAN_N-1:0] routeEn,
  output logic [CODE_W-1:0] trimCode,
  output logic              intReset,
  output logic              intRun,
  output logic              refEqual,
  output logic              refHighFirst,
  output logic              busy,
  output logic              done,
  output logic [CODE_W-1:0] finalCode,
  output logic [TIME_W-1:0] finalTime
);

  dpStrobe_t strb;
  logic timerAtPol, timerAtMax, tripped, lastBit;

  chgbal_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .timerAtPol (timerAtPol),
    .timerAtMax (timerAtMax),
    .tripped    (tripped),
    .lastBit    (lastBit),
    .strb       (strb),
    .busy       (busy),
    .done       (done),
    .intRun     (intRun),
    .intReset   (intReset),
    .refEqual   (refEqual)
  );

  chgbal_dp #(
    .CODE_W      (CODE_W),
    .CHAN_N      (CHAN_N),
    .POL_CYC     (POL_CYC),
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .srcMaskIn   (srcMaskIn),
    .snkMaskIn   (snkMaskIn),
    .routeMaskIn (routeMaskIn),
    .cmpIn       (cmpIn),
    .srcGate     (srcGate),
    .snkGate     (snkGate),
    .routeEn     (routeEn),
    .trimCode    (trimCode),
    .polarity    (refHighFirst),
    .finalCode   (finalCode),
    .finalTime   (finalTime),
    .timerAtPol  (timerAtPol),
    .timerAtMax  (timerAtMax),
    .tripped     (tripped),
    .lastBit     (lastBit)
  );

  // R1: gates closed whenever idle
  p_gates_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (srcGate == '0 && snkGate == '0 && routeEn == '0));

  // R10: trial code held while the integrator keeps running
  p_code_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    intRun && $past(intRun) |-> $stable(trimCode));

  // R10: reference mode held while the integrator keeps running
  p_ref_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    intRun && $past(intRun) |-> $stable(refEqual));

endmodule

// File: tb/chgbal_matcher_test.sv
module chgbal_matcher_test;

  localparam int CODE_W  = 16;
  localparam int CHAN_N  = 8;
  localparam int POL_CYC = 4;
  localparam int TMO     = 400;
  localparam int SCALE   = 300;
  localparam int TIME_W  = $clog2(TMO + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [CHAN_N-1:0] srcMaskIn = '0, snkMaskIn = '0, routeMaskIn = '0;
  logic cmpIn = 1'b0;
  logic [CHAN_N-1:0] srcGate, snkGate, routeEn;
  logic [CODE_W-1:0] trimCode, finalCode;
  logic intReset, intRun, refEqual, refHighFirst, busy, done;
  logic [TIME_W-1:0] finalTime;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;

  // integrator model settings: mode 0 exact target, 1 half-LSB offset, 2 instant trip
  int modelT = 0;
  int modelMode = 0;
  int runCnt = 0;

  always #2.5 clk = ~clk;

  chgbal_matcher #(
    .CODE_W(CODE_W), .CHAN_N(CHAN_N), .POL_CYC(POL_CYC), .TIMEOUT_CYC(TMO)
  ) uut (
    .clk(clk), .rstN(rstN), .start(start),
    .srcMaskIn(srcMaskIn), .snkMaskIn(snkMaskIn), .routeMaskIn(routeMaskIn),
    .cmpIn(cmpIn), .srcGate(srcGate), .snkGate(snkGate), .routeEn(routeEn),
    .trimCode(trimCode), .intReset(intReset), .intRun(intRun),
    .refEqual(refEqual), .refHighFirst(refHighFirst), .busy(busy),
    .done(done), .finalCode(finalCode), .finalTime(finalTime)
  );

  function automatic int errOf(int t, int code, int mode);
    if (mode == 1) return 2 * t + 1 - 2 * code;
    return t - code;
  endfunction

  function automatic int delayOf(int t, int code, int mode);
    int e;
    if (mode == 2) return 0;
    e = errOf(t, code, mode);
    if (e < 0) e = -e;
    if (e == 0) return 1 << 30;
    return SCALE / e;
  endfunction

  // analog stand-in driven between clock edges
  always @(negedge clk) begin
    if (intRun && refEqual) begin
      runCnt = 0;
      cmpIn <= (errOf(modelT, int'(trimCode), modelMode) > 0);
    end else if (intRun) begin
      runCnt = runCnt + 1;
      if (runCnt > delayOf(modelT, int'(trimCode), modelMode))
        cmpIn <= (errOf(modelT, int'(trimCode), modelMode) > 0);
      else
        cmpIn <= !(errOf(modelT, int'(trimCode), modelMode) > 0);
    end else begin
      runCnt = 0;
      cmpIn <= 1'b0;
    end
  end

  // reference of the whole search, written from the requirements
  task automatic predict(input int t, input int mode, output int code, output int tm);
    int approx = 0;
    int bestT = -1;
    code = 0;
    tm = 0;
    for (int k = CODE_W - 1; k >= 0; k--) begin
      int trial = approx | (1 << k);
      int d = delayOf(t, trial, mode);
      int tt = (d < TMO) ? d : TMO;
      if (tt > bestT) begin
        bestT = tt;
        code = trial;
        tm = tt;
      end
      if (errOf(t, trial, mode) > 0) approx = trial;
    end
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic pulseStart(input logic [CHAN_N-1:0] s, input logic [CHAN_N-1:0] k,
                            input logic [CHAN_N-1:0] r);
    @(negedge clk);
    srcMaskIn = s; snkMaskIn = k; routeMaskIn = r;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone();
    while (!done) @(negedge clk);
  endtask

  task automatic checkResult(input string req, input int t, input int mode);
    int ec, et;
    predict(t, mode, ec, et);
    check(finalCode == CODE_W'(ec), req, int'(finalCode), ec);
    check(finalTime == TIME_W'(et), req, int'(finalTime), et);
    @(negedge clk);
    check(!done && !busy, "R9 done one cycle", int'({done, busy}), 0);
  endtask

  task automatic testReset();
    check(!busy && !done && !intRun && intReset, "R1 idle controls",
          int'({busy, done, intRun, intReset}), 1);
    check(srcGate == '0 && snkGate == '0 && routeEn == '0, "R1 gates closed",
          int'({srcGate, snkGate, routeEn}), 0);
  endtask

  task automatic testTrialOrder();
    modelT = 'h9000; modelMode = 0;
    pulseStart(8'h01, 8'h02, 8'h03);
    while (!(intRun && refEqual)) @(negedge clk);
    check(trimCode == 16'h8000, "R3 first trial MSB", int'(trimCode), 'h8000);
    while (!(intRun && !refEqual)) @(negedge clk);
    check(refHighFirst == 1'b1, "R5 reference order from polarity 1", int'(refHighFirst), 1);
    while (!(intRun && refEqual)) @(negedge clk);
    check(trimCode == 16'hC000, "R7 bit kept on polarity 1", int'(trimCode), 'hC000);
    while (!(intRun && !refEqual)) @(negedge clk);
    check(refHighFirst == 1'b0, "R5 reference order from polarity 0", int'(refHighFirst), 0);
    while (!(intRun && refEqual)) @(negedge clk);
    check(trimCode == 16'hA000, "R7 bit cleared on polarity 0", int'(trimCode), 'hA000);
    waitDone();
    checkResult("R8 exact target", 'h9000, 0);
  endtask

  task automatic testPolarityWindow();
    int n = 0;
    modelT = 'h0100; modelMode = 0;
    pulseStart(8'h10, 8'h20, 8'h30);
    while (!(intRun && refEqual)) @(negedge clk);
    while (intRun && refEqual) begin
      n++;
      @(negedge clk);
    end
    check(n == POL_CYC, "R4 polarity window length", n, POL_CYC);
    waitDone();
    checkResult("R6 timeout on zero error", 'h0100, 0);
  endtask

  task automatic testOffset();
    modelT = 'h00FF; modelMode = 1;
    pulseStart(8'hF0, 8'h0F, 8'hFF);
    waitDone();
    checkResult("R5 finite trip time", 'h00FF, 1);
  endtask

  task automatic testTie();
    modelT = 'h3333; modelMode = 2;
    pulseStart(8'h80, 8'h40, 8'hC0);
    waitDone();
    checkResult("R8 earliest wins on tie", 'h3333, 2);
  endtask

  task automatic testIgnore();
    modelT = 'h5A5A; modelMode = 0;
    pulseStart(8'h0C, 8'h30, 8'h3C);
    check(srcGate == 8'h0C && snkGate == 8'h30 && routeEn == 8'h3C, "R2 masks applied",
          int'({srcGate, snkGate, routeEn}), 'h0C303C);
    repeat (50) @(negedge clk);
    srcMaskIn = 8'hFF; snkMaskIn = 8'hFF; routeMaskIn = 8'hFF;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check(srcGate == 8'h0C && snkGate == 8'h30 && routeEn == 8'h3C, "R2 mid-run changes ignored",
          int'({srcGate, snkGate, routeEn}), 'h0C303C);
    waitDone();
    checkResult("R2 result unaffected", 'h5A5A, 0);
    repeat (3) @(negedge clk);
    check(!busy, "R2 no queued run", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testTrialOrder();
    testPolarityWindow();
    testOffset();
    testTie();
    testIgnore();
    testReset();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual %0d expected below 150000", cycles);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule